// File: doc/BRIEF.md
# Window Watchdog Timer with Locked Control Register

This block supervises software through a two-phase timer. Once enabled, it first runs through a closed window of programmable length, in which servicing is not allowed. It then runs through an open window, in which software must service the timer. Servicing in the open window restarts the period. Servicing in the closed window is treated as a fault, and so is letting the open window run out. Either fault produces a one-cycle reset pulse and latches an event flag.

Software reaches the block through a simple memory-mapped register bus. Five 32-bit registers sit at word offsets 0x00 to 0x10. The control/status word can only be changed by a write that directly follows an unlock write, and that unlock is used up by the write. Servicing is a 0-to-1 edge of the service bit in the control/status word. It is not a write to a dedicated kick register.

Top module: `wwdt_top`

## Requirements
- R1: After reset, every register reads 0 and `wdt_rst` is low.
- R2: The function word at 0x08, the closed-window length at 0x0C and the open-window length at 0x10 are writable without unlock and read back as written. Any other offset reads 0.
- R3: Writing 0x00 with bit 0 set arms the unlock, which reads back as bit 0 of 0x00. The next write to 0x04 consumes the unlock, whether or not that write is applied.
- R4: A write to 0x04 while unlock is not armed changes nothing. The control/status word at 0x04 has bit 0 = run, bit 8 = service, bit 16 = event flag.
- R5: When an applied write to 0x04 sets run, counting starts. With closed length W1 and open length W2, the first expiry pulse appears on the (W1+W2+1)-th rising edge after the enabling write's edge.
- R6: An expiry asserts `wdt_rst` for exactly one cycle and sets the event flag. The period then restarts, and the next expiry comes W1+W2 edges later.
- R7: An applied write that raises the service bit from 0 to 1 with run set, in the open window, restarts the period without a pulse. The next expiry comes W1+W2 edges after that write's edge.
- R8: The same service edge during the closed window asserts `wdt_rst` on the following cycle and sets the event flag.
- R9: An applied write that raises the service bit while bit 16 is written as 1 clears the event flag, unless a fault sets the flag in the same cycle.
- R10: With W1 = 0 there is no closed window: a service edge right after enabling gives no pulse, and expiry then follows W2 edges after the service edge.
- R11: An applied write to 0x04 with run cleared stops counting, and no further pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` (combinational) |
| wdt_rst | output | 1 | One-cycle reset request on a watchdog fault |

## Verification
The bound checker watches the register lock and the run state on every cycle. It confirms that a write to the control/status word without an armed unlock leaves the run and service bits unchanged. It also confirms that every write to that word leaves the unlock cleared, that any reset pulse coincides with a set event flag, and that a cleared run bit drives the window engine idle.

The exact cycle counts of the closed and open windows can only be shown by the bench's timed scenarios. The same holds for the difference between an open-window service and an early one, for the behaviour with a zero-length closed window, and for the fact that no pulse appears once the timer is disabled.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  // register byte offsets
  localparam int OFS_UNLOCK = 'h00;
  localparam int OFS_STAT   = 'h04;
  localparam int OFS_FUNC   = 'h08;
  localparam int OFS_WIN1   = 'h0C;
  localparam int OFS_WIN2   = 'h10;
  // control/status bit positions
  localparam int BIT_RUN  = 0;
  localparam int BIT_SVC  = 8;
  localparam int BIT_FLAG = 16;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2
  } wwdt_phase_e;
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              evt_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              arm_o,
  output logic              run_o,
  output logic              svc_o,
  output logic              flag_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] win1_o,
  output logic [DATA_W-1:0] win2_o
);
  localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFS_UNLOCK);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_FUNC   = ADDR_W'(OFS_FUNC);
  localparam logic [ADDR_W-1:0] A_WIN1   = ADDR_W'(OFS_WIN1);
  localparam logic [ADDR_W-1:0] A_WIN2   = ADDR_W'(OFS_WIN2);

  logic              arm_q, arm_n;
  logic              run_q, run_n;
  logic              svc_q, svc_n;
  logic              flag_q, flag_n;
  logic [DATA_W-1:0] func_q, win1_q, win2_q;
  logic              wr_hit, stat_wr, stat_apply, svc_rise;
  logic              func_en, win1_en, win2_en, stat_en;

  assign wr_hit     = bus_sel & bus_wr;
  assign stat_wr    = wr_hit & (bus_addr == A_STAT);
  assign stat_apply = stat_wr & arm_q;
  assign svc_rise   = stat_apply & bus_wdata[BIT_SVC] & ~svc_q;
  assign func_en    = wr_hit & (bus_addr == A_FUNC);
  assign win1_en    = wr_hit & (bus_addr == A_WIN1);
  assign win2_en    = wr_hit & (bus_addr == A_WIN2);
  assign stat_en    = stat_apply | evt_i;

  // next state of the lock and the control/status word
  always_comb begin
    arm_n  = arm_q;
    run_n  = run_q;
    svc_n  = svc_q;
    flag_n = flag_q;
    if (wr_hit && bus_addr == A_UNLOCK) arm_n = bus_wdata[0];
    else if (stat_wr)                   arm_n = 1'b0;
    if (stat_apply) begin
      run_n = bus_wdata[BIT_RUN];
      svc_n = bus_wdata[BIT_SVC];
    end
    if (svc_rise && bus_wdata[BIT_FLAG]) flag_n = 1'b0;
    if (evt_i)                           flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      run_q  <= 1'b0;
      svc_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      arm_q <= arm_n;
      if (stat_en) begin
        run_q  <= run_n;
        svc_q  <= svc_n;
        flag_q <= flag_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      win1_q <= '0;
      win2_q <= '0;
    end else begin
      if (func_en) func_q <= bus_wdata;
      if (win1_en) win1_q <= bus_wdata;
      if (win2_en) win2_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_UNLOCK) bus_rdata[0] = arm_q;
    else if (bus_addr == A_STAT) begin
      bus_rdata[BIT_RUN]  = run_q;
      bus_rdata[BIT_SVC]  = svc_q;
      bus_rdata[BIT_FLAG] = flag_q;
    end
    else if (bus_addr == A_FUNC) bus_rdata = func_q;
    else if (bus_addr == A_WIN1) bus_rdata = win1_q;
    else if (bus_addr == A_WIN2) bus_rdata = win2_q;
  end

  assign arm_o  = arm_q;
  assign run_o  = run_q;
  assign svc_o  = svc_q;
  assign flag_o = flag_q;
  assign kick_o = svc_rise & bus_wdata[BIT_RUN];
  assign win1_o = win1_q;
  assign win2_o = win2_q;
endmodule

// File: rtl/wwdt_engine.sv
module wwdt_engine
  import wwdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] win1_i,
  input  logic [CNT_W-1:0] win2_i,
  output wwdt_phase_e      phase_o,
  output logic             evt_o
);
  wwdt_phase_e      phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             last;
  logic             cnt_en;

  assign last   = (cnt_q <= CNT_W'(1));
  assign cnt_en = run_i | (phase_q != PH_IDLE);

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    evt_o   = 1'b0;
    if (!run_i) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
    end else if (phase_q == PH_IDLE || kick_i || (last && phase_q == PH_OPEN)) begin
      // start a new period; an early kick or an expiry is a fault
      evt_o = (phase_q == PH_OPEN && !kick_i) || (phase_q == PH_CLOSED && kick_i);
      if (win1_i != '0) begin
        phase_n = PH_CLOSED;
        cnt_n   = win1_i;
      end else begin
        phase_n = PH_OPEN;
        cnt_n   = win2_i;
      end
    end else if (last) begin
      phase_n = PH_OPEN;
      cnt_n   = win2_i;
    end else begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   srst_n;
  logic                   arm, run, svc, flag, kick, evt, rst_q;
  logic [DATA_W-1:0]      win1, win2;
  wwdt_phase_e            phase;

  // reset: asserted at once, released after SYNC_STAGES edges
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign srst_n = sync_q[SYNC_STAGES-1];

  wwdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(srst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .evt_i(evt), .bus_rdata(bus_rdata),
    .arm_o(arm), .run_o(run), .svc_o(svc), .flag_o(flag), .kick_o(kick),
    .win1_o(win1), .win2_o(win2)
  );

  wwdt_engine #(.CNT_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(srst_n),
    .run_i(run), .kick_i(kick), .win1_i(win1), .win2_i(win2),
    .phase_o(phase), .evt_o(evt)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rst_q <= 1'b0;
    else         rst_q <= evt;
  end
  assign wdt_rst = rst_q;
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker
  import wwdt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              arm,
  input logic              run,
  input logic              svc,
  input logic              flag,
  input wwdt_phase_e       phase,
  input logic              wdt_rst
);
  logic stat_wr;
  assign stat_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

  // R4: a locked write must not move run or service bits
  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!srst_n)
    (stat_wr && !arm) |=> ($stable(run) && $stable(svc)));

  // R3: any control/status write uses up the unlock
  a_r3_unlock_consumed: assert property (@(posedge clk) disable iff (!srst_n)
    stat_wr |=> !arm);

  // R6: a reset pulse is always accompanied by a set flag
  a_r6_pulse_with_flag: assert property (@(posedge clk) disable iff (!srst_n)
    wdt_rst |-> flag);

  // R11: stopping the timer returns the engine to idle
  a_r11_stop_goes_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !run |=> (phase == PH_IDLE));
endmodule

bind wwdt_top wwdt_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .arm(arm), .run(run), .svc(svc), .flag(flag), .phase(phase), .wdt_rst(wdt_rst)
);

// File: tb/tb_wwdt_top.sv
module tb_wwdt_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  wwdt_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (wdt_rst) pulses++;

  // {unlock first, do write, addr, wdata, expected readback}
  localparam int NV = 10;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 1'b1, 5'h0C, 32'h0000_0020, 32'h0000_0020},
    {1'b0, 1'b1, 5'h10, 32'h0000_0040, 32'h0000_0040},
    {1'b0, 1'b1, 5'h08, 32'hA5A5_0003, 32'hA5A5_0003},
    {1'b0, 1'b1, 5'h04, 32'h0000_0001, 32'h0000_0000},
    {1'b1, 1'b1, 5'h04, 32'h0000_0100, 32'h0000_0100},
    {1'b1, 1'b1, 5'h04, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 1'b1, 5'h00, 32'h0000_0001, 32'h0000_0001},
    {1'b0, 1'b1, 5'h04, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 1'b0, 5'h00, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 1'b0, 5'h14, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic uwr(input logic [31:0] d);
    wr(5'h00, 32'h1);
    wr(5'h04, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // edges until the next pulse, sampled just after each rising edge
  task automatic wait_pulse(output int n);
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #1;
      n++;
      if (wdt_rst) break;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, p0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(wdt_rst == 1'b0, "R1 rst low", {31'b0, wdt_rst}, 32'h0);
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), v);
      check(v == 32'h0, "R1 reset read", v, 32'h0);
    end

    // table walk: R2 readback, R3 unlock, R4 locked write
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) wr(5'h00, 32'h1);
      if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      check(v == VEC[i][31:0], "R2/R3/R4 vector", v, VEC[i][31:0]);
    end

    // R5 first expiry, R6 pulse width and period
    wr(5'h0C, 32'd3);
    wr(5'h10, 32'd5);
    uwr(32'h1);
    wait_pulse(n);
    check(n == 9, "R5 first expiry edge", n, 9);
    @(posedge clk); #1;
    check(wdt_rst == 1'b0, "R6 single-cycle pulse", {31'b0, wdt_rst}, 32'h0);
    rd(5'h04, v);
    check(v == 32'h0001_0001, "R6 flag set", v, 32'h0001_0001);
    wait_pulse(n);
    check(n == 7, "R6 next expiry", n, 7);

    // R7 open-window service, R9 flag clear
    uwr(32'h0);
    wr(5'h0C, 32'd10);
    wr(5'h10, 32'd40);
    uwr(32'h1);
    p0 = pulses;
    repeat (20) @(negedge clk);
    uwr(32'h0001_0101);
    rd(5'h04, v);
    check(v == 32'h0000_0101, "R9 flag cleared by service", v, 32'h0000_0101);
    wait_pulse(n);
    check(n == 50, "R7 restart from service", n, 50);
    check(pulses == p0, "R7 no pulse on open service", pulses, p0);

    // R8 early service
    uwr(32'h0);
    uwr(32'h0001_0100);
    rd(5'h04, v);
    check(v == 32'h0000_0100, "R9 clear while stopped", v, 32'h0000_0100);
    uwr(32'h0);
    uwr(32'h1);
    uwr(32'h101);
    check(wdt_rst == 1'b1, "R8 early service pulse", {31'b0, wdt_rst}, 32'h1);
    rd(5'h04, v);
    check(v == 32'h0001_0101, "R8 flag set", v, 32'h0001_0101);

    // R10 zero-length closed window
    uwr(32'h0);
    wr(5'h0C, 32'd0);
    wr(5'h10, 32'd5);
    uwr(32'h1);
    uwr(32'h101);
    check(wdt_rst == 1'b0, "R10 no closed window", {31'b0, wdt_rst}, 32'h0);
    wait_pulse(n);
    check(n == 5, "R10 expiry after open window", n, 5);

    // R4 locked write while running does not stop it
    @(negedge clk);
    wr(5'h04, 32'h0);
    rd(5'h04, v);
    check(v == 32'h0001_0101, "R4 locked stop ignored", v, 32'h0001_0101);
    wait_pulse(n);
    check(n >= 1 && n <= 6, "R4 still running", n, 6);

    // R11 stop
    uwr(32'h0);
    @(negedge clk); #1;
    p0 = pulses;
    repeat (30) @(negedge clk);
    #1;
    check(pulses == p0, "R11 stopped no pulse", pulses, p0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule